// File: doc/BRIEF.md
# Multi-Channel Register Window Decoder

This block sits between a simple synchronous host register port and fourteen independent two-wire bus channel engines. It splits a 4 KiB register space into a global window at the bottom and one 64-byte window per channel. It forwards each host access to the register port of the channel that owns the address. The channel windows form two groups with a gap between them. The first seven channels fill the slots directly above the global window. The remaining seven start above a reserved hole that a buffer pool occupies. The pool ranges, and everything above the last channel, decode to nothing.

The block also gathers interrupt requests. Each channel reports a raise pulse and a level that means "my masked status is nonzero". A per-channel bit in a global status word latches on a raise while the channel is active. It drops once the channel reports an all-zero status. The host reads this word at global offset 0x00. One combined interrupt line is asserted while any bit is set.

Top module: `chan_window_decoder`

## Requirements
- R1: For channel index i in 0..6, a word-aligned host address in [0x40*(i+1), 0x40*(i+1)+0x3F] asserts bit i of `ch_sel` and no other bit. `ch_addr` carries address bits [5:2].
- R2: For channel index i in 7..13, a host address in [0x40*(i+5), 0x40*(i+5)+0x3F] asserts bit i of `ch_sel` and no other bit. This covers 0x300..0x4BF.
- R3: In the same cycle, `ch_we` and `ch_re` equal `ch_sel` gated by `host_we` and `host_re`, and `ch_wdata` equals `host_wdata`.
- R4: Addresses 0x200..0x2FF and 0x4C0..0xFFF select no channel and raise no strobe. A read there returns 0xFFFFFFFF.
- R5: A read at global offset 0x000 returns the status word in bits [13:0], with zeros above. A read at any other global offset (0x004..0x03C) returns 0xFFFFFFFF.
- R6: A host write anywhere in the global window leaves the status word unchanged and strobes no channel.
- R7: If `ch_raise[n]` and `ch_active[n]` are both high at a clock edge, status bit n is set after that edge.
- R8: If `ch_active[n]` is low at a clock edge, status bit n is clear after that edge. A raise without active does not set the bit. Active without a raise leaves the bit as it was.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: After reset, the status word is zero, `irq` is low and `host_rdata` is zero.
- R11: Read data is registered. `host_rdata` shows the value selected at the edge where `host_re` was high, and it holds until the next read. For a channel window, that value is the channel's `ch_rdata` word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 12 | Host byte address, word aligned |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 32 | Registered read data |
| ch_sel | output | 14 | One-hot channel window select |
| ch_we | output | 14 | Per-channel write strobe |
| ch_re | output | 14 | Per-channel read strobe |
| ch_addr | output | 4 | Word offset inside the channel window |
| ch_wdata | output | 32 | Write data forwarded to channels |
| ch_rdata | input | 448 | Channel read words, channel i in bits [32i+31:32i] |
| ch_raise | input | 14 | Per-channel interrupt raise pulse |
| ch_active | input | 14 | Per-channel masked status is nonzero |
| irq | output | 1 | Combined interrupt |

## Verification
A decode error in the slot comparison shows up in the same cycle as a wrong or doubled bit on `ch_sel` and the strobes. On a read, it also shows up one edge later as wrong data. A wrong status bit becomes visible on `irq` one edge after the input that caused it, unless other bits are already set. It always shows up in the next read of global offset 0x000. For that reason, the random stimulus reads the global word often and compares `irq` on every cycle.

// File: rtl/chan_window_decoder.sv
module chan_window_decoder #(
  parameter int N_CH      = 14,
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter int WIN_BYTES = 64,
  parameter int LOW_CNT   = 7,
  parameter int LOW_SLOT  = 1,
  parameter int HIGH_SLOT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_we,
  input  logic              host_re,
  output logic [DW-1:0]     host_rdata,
  output logic [N_CH-1:0]   ch_sel,
  output logic [N_CH-1:0]   ch_we,
  output logic [N_CH-1:0]   ch_re,
  output logic [$clog2(WIN_BYTES)-3:0] ch_addr,
  output logic [DW-1:0]     ch_wdata,
  input  logic [N_CH*DW-1:0] ch_rdata,
  input  logic [N_CH-1:0]   ch_raise,
  input  logic [N_CH-1:0]   ch_active,
  output logic              irq
);
  localparam int OFS_W  = $clog2(WIN_BYTES);
  localparam int SLOT_W = AW - OFS_W;
  localparam int WORD_W = OFS_W - 2;

  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] word_ofs;
  logic [N_CH-1:0]   hit;
  logic              glob_hit;
  logic [N_CH-1:0]   gsts;
  logic [DW-1:0]     rd_next;
  logic              unused_lsb;

  assign slot       = host_addr[AW-1:OFS_W];
  assign word_ofs   = host_addr[OFS_W-1:2];
  assign glob_hit   = (slot == '0);
  assign unused_lsb = ^host_addr[1:0];

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    localparam int SL = (i < LOW_CNT) ? i + LOW_SLOT : i - LOW_CNT + HIGH_SLOT;
    assign hit[i] = (slot == SLOT_W'(SL));
  end

  assign ch_sel   = hit;
  assign ch_we    = hit & {N_CH{host_we}};
  assign ch_re    = hit & {N_CH{host_re}};
  assign ch_addr  = word_ofs;
  assign ch_wdata = host_wdata;

  always_comb begin
    rd_next = '1;
    if (glob_hit && word_ofs == '0) rd_next = DW'(gsts);
    for (int i = 0; i < N_CH; i++)
      if (hit[i]) rd_next = ch_rdata[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
      gsts       <= '0;
    end else begin
      if (host_re) host_rdata <= rd_next;
      gsts <= (gsts | ch_raise) & ch_active;
    end
  end

  assign irq = |gsts;

  p_onehot_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  p_pool_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr >= AW'('h200) && host_addr < AW'('h300)) |-> (ch_sel == '0));

  p_glob_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr < AW'(WIN_BYTES)) |-> (ch_we == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(host_rdata));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_raise[i] && ch_active[i]) |=> gsts[i]);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_active[i] |=> !gsts[i]);
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_raise[i] && ch_active[i]) |=> irq);
  end
endmodule

// File: tb/chan_window_decoder_tb.sv
module chan_window_decoder_tb_top;
  localparam int N = 14;
  logic clk = 0, rst_n = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_we = 0, host_re = 0;
  logic [N-1:0] ch_sel, ch_we, ch_re, ch_raise = 0, ch_active = 0;
  logic [3:0] ch_addr;
  logic [31:0] ch_wdata;
  logic [N*32-1:0] ch_rdata = 0;
  logic irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_rd = 0;
  logic [N-1:0] exp_sts = 0;

  always #10 clk = ~clk;

  chan_window_decoder dut_i (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ch_of(logic [11:0] a);
    int s = int'(a[11:6]);
    if (s >= 1 && s <= 7) return s - 1;
    if (s >= 12 && s <= 18) return s - 5;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    int c = ch_of(a);
    if (c >= 0) return ch_rdata[c*32 +: 32];
    if (a[11:6] == 0 && a[5:2] == 0) return {18'b0, exp_sts};
    return 32'hFFFF_FFFF;
  endfunction

  // one cycle: check registered outputs, drive, check decode, advance model
  task automatic step(logic [11:0] a, bit we, bit re, logic [31:0] wd,
                      logic [N-1:0] rs, logic [N-1:0] ac);
    int c;
    logic [N-1:0] es;
    chk(host_rdata === exp_rd, "R11 rdata", host_rdata, exp_rd);
    chk(irq === (exp_sts != 0), "R9 irq", {31'b0, irq}, {31'b0, exp_sts != 0});
    host_addr = a; host_we = we; host_re = re; host_wdata = wd;
    ch_raise = rs; ch_active = ac;
    for (int k = 0; k < N; k++) ch_rdata[k*32 +: 32] = $urandom;
    #1;
    c = ch_of(a);
    es = (c >= 0) ? (N'(1) << c) : '0;
    chk(ch_sel === es, (c < 0) ? "R4 sel" : (c < 7) ? "R1 sel" : "R2 sel",
        {18'b0, ch_sel}, {18'b0, es});
    chk(ch_we === (es & {N{we}}) && ch_re === (es & {N{re}}) && ch_wdata === wd,
        "R3 strobes", {18'b0, ch_we}, {18'b0, es & {N{we}}});
    if (c >= 0) chk(ch_addr === a[5:2], "R1 R2 ch_addr", {28'b0, ch_addr}, {28'b0, a[5:2]});
    if (re) exp_rd = model_read(a);
    exp_sts = (exp_sts | rs) & ac;
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a);
    step(a, 0, 1, 0, 0, exp_sts);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [11:0] ra;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(host_rdata === 0, "R10 rdata reset", host_rdata, 0);
    chk(irq === 0, "R10 irq reset", {31'b0, irq}, 0);
    rd(12'h000);
    // R5 global offsets
    rd(12'h004); rd(12'h03C);
    // R1/R2/R4 boundaries
    rd(12'h040); rd(12'h1FC); rd(12'h200); rd(12'h2FC);
    rd(12'h300); rd(12'h4BC); rd(12'h4C0); rd(12'hFFC);
    // R8: raise without active does not set; active without raise does not set
    step(12'h000, 0, 0, 0, 14'h0001, 14'h0000);
    step(12'h000, 0, 0, 0, 14'h0000, 14'h3FFF);
    rd(12'h000);
    // R7 set ch0 and ch13
    step(12'h000, 0, 0, 0, 14'h2001, 14'h3FFF);
    rd(12'h000);
    // R6 global write leaves status
    step(12'h000, 1, 0, 32'h0, 14'h0, 14'h3FFF);
    step(12'h008, 1, 0, 32'hFFFF_FFFF, 14'h0, 14'h3FFF);
    rd(12'h000);
    // R8 clear ch0
    step(12'h000, 0, 0, 0, 14'h0, 14'h3FFE);
    rd(12'h000);
    step(12'h000, 0, 0, 0, 14'h0, 14'h0000);
    rd(12'h000);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] rs, ac;
      ra = ($urandom % 4 == 0) ? 12'h000 : 12'($urandom) & 12'hFFC;
      rs = N'($urandom) & N'($urandom);
      ac = N'($urandom) | N'($urandom);
      step(ra, 1'($urandom), 1'($urandom), $urandom, rs, ac);
    end
    rd(12'h000);
    step(12'h000, 0, 0, 0, 0, exp_sts);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule